// File: doc/BRIEF.md
# Configurable Output Macrocell for a Small Programmable-Logic Device

This block is a single output cell of a small sum-of-products logic device. It receives eight product-term results from the logic array and forms the value, the drive enable and the feedback signal of one device pin. Four configuration bits set it up: two device-wide bits (`gbl_noreg`, `gbl_mux`) and two per-cell bits (`loc_mode`, `loc_pol`). The three mode bits `{gbl_noreg, gbl_mux, loc_mode}` select one of five operating modes, and `loc_pol` sets the output polarity. The cell also contains a D flip-flop that can be loaded directly from a test preload port.

The decoded mode, an enumerated type, works as the cell's operating state. `CM_REG_OUT` (010) is the registered output. `CM_REG_IO` (011) is a combinatorial I/O in a registered device. `CM_COMB_OUT` (100) is a dedicated combinatorial output. `CM_DED_IN` (101) is a dedicated input. `CM_COMB_IO` (111) is a combinatorial I/O in a device without registers. `CM_UNUSED` covers every other code.

The flip-flop has three transitions. The power-up reset clears it. A preload loads it from `pre_val`. A capture loads it from the full sum on every rising clock edge. It stores the pad value inverted, so after a clear a registered pad reads HIGH.

The integrating level sets `CELL_ID`. End cell 0 takes its adjacent-pin source from the OE pin, and end cell `NUM_CELLS-1` takes it from the clock pin level. The two middle cells (3 and 4 by default) give no feedback in the dedicated output mode.

Top module: `pld_macrocell`

## Requirements
- R1: In mode 010 the flip-flop captures the full sum on each rising `clk` edge. `pad_data` shows the captured value after that edge, `fb_out` equals `pad_data`, and `pad_oe` is the inverse of `oe_pin_n`.
- R2: The sum is the OR of the product terms in use. With `loc_pol`=1 the pad value equals the sum (active high). With `loc_pol`=0 it is the inverted sum (active low). This holds in the registered mode and in every combinatorial mode.
- R3: In mode 011, `pad_data` is formed from terms bits 6..0 only. `pad_oe` equals term bit 7, and `fb_out` equals `io_pin`.
- R4: In mode 100, `pad_data` is formed from all eight terms and `pad_oe` is 1. `fb_out` is the adjacent-pin source, except in the two middle cells, where `fb_out` is 0.
- R5: In mode 101, `pad_oe` is 0, `pad_data` is 0, and `fb_out` is the adjacent-pin source.
- R6: In mode 111, `pad_data` is formed from terms bits 6..0, `pad_oe` equals term bit 7, and `fb_out` equals `io_pin` (not in the end cells).
- R7: In cell 0 the adjacent-pin source is the `oe_pin_n` level, and in cell `NUM_CELLS-1` it is `clk_pin_lvl`. End cells select that source whenever `gbl_noreg`=1, including in mode 111. In mode 010 they still feed back the register.
- R8: While `rst_n` is low the flip-flop is cleared. In mode 010 this gives `pad_data`=1 and `fb_out`=1.
- R9: When `pre_en` is high at a rising edge, the flip-flop loads `pre_val` instead of the sum. In mode 010, `pad_data` and `fb_out` equal `pre_val` after that edge.
- R10: Any mode code not listed above gives `pad_oe`=0 and `pad_data`=0, with `fb_out` equal to `io_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; the flip-flop captures on the rising edge |
| rst_n | input | 1 | Active-low power-up clear of the flip-flop |
| terms | input | NUM_TERMS | Product-term results from the logic array; the top bit is the enable term |
| gbl_noreg | input | 1 | Device-wide bit: 1 means the device uses no registers |
| gbl_mux | input | 1 | Device-wide routing bit |
| loc_mode | input | 1 | Per-cell mode bit |
| loc_pol | input | 1 | Per-cell polarity: 1 active high, 0 active low |
| oe_pin_n | input | 1 | Level of the device output-enable pin (active low) |
| clk_pin_lvl | input | 1 | Level of the clock pin, used as data by the last end cell |
| io_pin | input | 1 | Value present on this cell's own pin |
| adj_pin | input | 1 | Value on the neighbouring pin |
| pre_en | input | 1 | Test preload strobe |
| pre_val | input | 1 | Pad value to preload |
| pad_data | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback into the logic array |

## Verification
The hardest situation to reach is the feedback selection in the end and middle cells. The same mode code routes feedback differently depending on the cell's position, and this cannot be seen from a single cell instance. The bench therefore runs a general cell, both end cells and a middle cell side by side on shared stimulus. It sets the OE pin, the clock pin level, the adjacent pin and the own pin to values that differ from one another, so each mode shows which source was picked. Preload is checked with terms that would capture the opposite value, so an override that fails shows up on the pad.

// File: rtl/pld_mc_pkg.sv
`timescale 1ns/1ps
package pld_mc_pkg;

    // Decoded operating mode of one cell, from {gbl_noreg, gbl_mux, loc_mode}
    typedef enum logic [2:0] {
        CM_REG_OUT  = 3'd0,
        CM_REG_IO   = 3'd1,
        CM_COMB_OUT = 3'd2,
        CM_DED_IN   = 3'd3,
        CM_COMB_IO  = 3'd4,
        CM_UNUSED   = 3'd5
    } cell_mode_e;

endpackage

// File: rtl/pld_mc_decode.sv
`timescale 1ns/1ps
module pld_mc_decode
    import pld_mc_pkg::*;
(
    input  logic       gbl_noreg,
    input  logic       gbl_mux,
    input  logic       loc_mode,
    output cell_mode_e mode
);

    always_comb begin
        unique case ({gbl_noreg, gbl_mux, loc_mode})
            3'b010:  mode = CM_REG_OUT;
            3'b011:  mode = CM_REG_IO;
            3'b100:  mode = CM_COMB_OUT;
            3'b101:  mode = CM_DED_IN;
            3'b111:  mode = CM_COMB_IO;
            default: mode = CM_UNUSED;
        endcase
    end

endmodule

// File: rtl/pld_mc_terms.sv
`timescale 1ns/1ps
module pld_mc_terms #(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] terms,
    input  logic                 loc_pol,
    output logic                 full_val,
    output logic                 part_val,
    output logic                 en_term
);

    localparam int EN_IDX = NUM_TERMS - 1;

    logic sum_full;
    logic sum_part;

    // The enable term is the top one; the partial sum leaves it out
    assign sum_full = |terms;
    assign sum_part = |terms[EN_IDX-1:0];
    assign en_term  = terms[EN_IDX];

    // Polarity XOR: loc_pol=1 passes the sum, loc_pol=0 inverts it
    assign full_val = sum_full ^ ~loc_pol;
    assign part_val = sum_part ^ ~loc_pol;

endmodule

// File: rtl/pld_mc_flop.sv
`timescale 1ns/1ps
module pld_mc_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic pre_en,
    input  logic pre_val,
    input  logic d_pad,
    output logic q_pad
);

    // Stored inverted: a cleared flop presents a HIGH pad value
    logic q_store;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_store <= 1'b0;
        end else if (pre_en) begin
            q_store <= ~pre_val;
        end else begin
            q_store <= ~d_pad;
        end
    end

    assign q_pad = ~q_store;

endmodule

// File: rtl/pld_mc_fbsel.sv
`timescale 1ns/1ps
module pld_mc_fbsel
    import pld_mc_pkg::*;
#(
    parameter int CELL_ID   = 1,
    parameter int NUM_CELLS = 8
) (
    input  cell_mode_e mode,
    input  logic       gbl_noreg,
    input  logic       gbl_mux,
    input  logic       reg_val,
    input  logic       io_pin,
    input  logic       adj_pin,
    input  logic       oe_pin_n,
    input  logic       clk_pin_lvl,
    output logic       fb_out
);

    localparam int  LAST_ID = NUM_CELLS - 1;
    localparam int  MID_LO  = NUM_CELLS / 2 - 1;
    localparam int  MID_HI  = NUM_CELLS / 2;
    localparam bit  IS_END  = (CELL_ID == 0) || (CELL_ID == LAST_ID);
    localparam bit  IS_MID  = (CELL_ID == MID_LO) || (CELL_ID == MID_HI);

    logic adj_src;
    logic take_adj;
    logic comb_out_fb;

    // End cells borrow the dedicated pins as their neighbour
    assign adj_src  = (CELL_ID == 0)       ? oe_pin_n    :
                      (CELL_ID == LAST_ID) ? clk_pin_lvl : adj_pin;

    // End cells steer by the no-register bit instead of the routing bit
    assign take_adj = IS_END ? gbl_noreg : ~gbl_mux;

    generate
        if (IS_MID) begin : g_mid
            assign comb_out_fb = 1'b0;
        end else begin : g_std
            assign comb_out_fb = adj_src;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            CM_REG_OUT:  fb_out = take_adj ? adj_src : reg_val;
            CM_REG_IO:   fb_out = io_pin;
            CM_COMB_OUT: fb_out = comb_out_fb;
            CM_DED_IN:   fb_out = adj_src;
            CM_COMB_IO:  fb_out = take_adj ? adj_src : io_pin;
            default:     fb_out = io_pin;
        endcase
    end

endmodule

// File: rtl/pld_macrocell.sv
`timescale 1ns/1ps
module pld_macrocell
    import pld_mc_pkg::*;
#(
    parameter int CELL_ID   = 1,
    parameter int NUM_CELLS = 8,
    parameter int NUM_TERMS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TERMS-1:0] terms,
    input  logic                 gbl_noreg,
    input  logic                 gbl_mux,
    input  logic                 loc_mode,
    input  logic                 loc_pol,
    input  logic                 oe_pin_n,
    input  logic                 clk_pin_lvl,
    input  logic                 io_pin,
    input  logic                 adj_pin,
    input  logic                 pre_en,
    input  logic                 pre_val,
    output logic                 pad_data,
    output logic                 pad_oe,
    output logic                 fb_out
);

    cell_mode_e mode;
    logic       full_val;
    logic       part_val;
    logic       en_term;
    logic       reg_pad;

    pld_mc_decode u_decode (
        .gbl_noreg (gbl_noreg),
        .gbl_mux   (gbl_mux),
        .loc_mode  (loc_mode),
        .mode      (mode)
    );

    pld_mc_terms #(.NUM_TERMS(NUM_TERMS)) u_terms (
        .terms    (terms),
        .loc_pol  (loc_pol),
        .full_val (full_val),
        .part_val (part_val),
        .en_term  (en_term)
    );

    pld_mc_flop u_flop (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_en  (pre_en),
        .pre_val (pre_val),
        .d_pad   (full_val),
        .q_pad   (reg_pad)
    );

    pld_mc_fbsel #(.CELL_ID(CELL_ID), .NUM_CELLS(NUM_CELLS)) u_fbsel (
        .mode        (mode),
        .gbl_noreg   (gbl_noreg),
        .gbl_mux     (gbl_mux),
        .reg_val     (reg_pad),
        .io_pin      (io_pin),
        .adj_pin     (adj_pin),
        .oe_pin_n    (oe_pin_n),
        .clk_pin_lvl (clk_pin_lvl),
        .fb_out      (fb_out)
    );

    // Output process: pad value and enable per operating mode
    always_comb begin
        unique case (mode)
            CM_REG_OUT: begin
                pad_data = reg_pad;
                pad_oe   = ~oe_pin_n;
            end
            CM_REG_IO, CM_COMB_IO: begin
                pad_data = part_val;
                pad_oe   = en_term;
            end
            CM_COMB_OUT: begin
                pad_data = full_val;
                pad_oe   = 1'b1;
            end
            default: begin
                pad_data = 1'b0;
                pad_oe   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pld_macrocell_chk.sv
`timescale 1ns/1ps
module pld_macrocell_chk #(
    parameter int NUM_TERMS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_TERMS-1:0] terms,
    input logic                 gbl_noreg,
    input logic                 gbl_mux,
    input logic                 loc_mode,
    input logic                 loc_pol,
    input logic                 oe_pin_n,
    input logic                 io_pin,
    input logic                 pre_en,
    input logic                 pre_val,
    input logic                 pad_data,
    input logic                 pad_oe,
    input logic                 fb_out
);

    logic m_reg, m_regio, m_cout, m_in, m_unused;
    assign m_reg    = ({gbl_noreg, gbl_mux, loc_mode} == 3'b010);
    assign m_regio  = ({gbl_noreg, gbl_mux, loc_mode} == 3'b011);
    assign m_cout   = ({gbl_noreg, gbl_mux, loc_mode} == 3'b100);
    assign m_in     = ({gbl_noreg, gbl_mux, loc_mode} == 3'b101);
    assign m_unused = !m_reg && !m_regio && !m_cout && !m_in &&
                      ({gbl_noreg, gbl_mux, loc_mode} != 3'b111);

    // R1
    reg_oe_follows_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_reg |-> (pad_oe == !oe_pin_n));

    // R1
    reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_reg && !pre_en) |=> (!m_reg || (pad_data == $past((|terms) ^ !loc_pol))));

    // R9
    preload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |=> (!m_reg || (pad_data == $past(pre_val) && fb_out == $past(pre_val))));

    // R3
    regio_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_regio |-> (pad_oe == terms[NUM_TERMS-1] && fb_out == io_pin));

    // R4
    comb_out_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_cout |-> pad_oe);

    // R5
    input_mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_in |-> (!pad_oe && !pad_data));

    // R10
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_unused |-> (!pad_oe && !pad_data && fb_out == io_pin));

endmodule

bind pld_macrocell pld_macrocell_chk #(.NUM_TERMS(NUM_TERMS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .terms     (terms),
    .gbl_noreg (gbl_noreg),
    .gbl_mux   (gbl_mux),
    .loc_mode  (loc_mode),
    .loc_pol   (loc_pol),
    .oe_pin_n  (oe_pin_n),
    .io_pin    (io_pin),
    .pre_en    (pre_en),
    .pre_val   (pre_val),
    .pad_data  (pad_data),
    .pad_oe    (pad_oe),
    .fb_out    (fb_out)
);

// File: tb/pld_macrocell_test.sv
`timescale 1ns/1ps
module pld_macrocell_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] terms = 8'h00;
    logic       gbl_noreg = 1'b0, gbl_mux = 1'b1, loc_mode = 1'b0, loc_pol = 1'b1;
    logic       oe_pin_n = 1'b0, clk_pin_lvl = 1'b0, io_pin = 1'b0, adj_pin = 1'b0;
    logic       pre_en = 1'b0, pre_val = 1'b0;

    logic act_pd [4];
    logic act_oe [4];
    logic act_fb [4];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int    unit;
        string tag;
        logic  pd;
        logic  oe;
        logic  fb;
    } exp_t;

    exp_t exp_q [$];

    always #2 clk = ~clk;

    // Unit 0 general cell, 1 first end cell, 2 last end cell, 3 middle cell
    pld_macrocell #(.CELL_ID(1)) uut (
        .clk(clk), .rst_n(rst_n), .terms(terms), .gbl_noreg(gbl_noreg), .gbl_mux(gbl_mux),
        .loc_mode(loc_mode), .loc_pol(loc_pol), .oe_pin_n(oe_pin_n), .clk_pin_lvl(clk_pin_lvl),
        .io_pin(io_pin), .adj_pin(adj_pin), .pre_en(pre_en), .pre_val(pre_val),
        .pad_data(act_pd[0]), .pad_oe(act_oe[0]), .fb_out(act_fb[0]));

    pld_macrocell #(.CELL_ID(0)) uut_end0 (
        .clk(clk), .rst_n(rst_n), .terms(terms), .gbl_noreg(gbl_noreg), .gbl_mux(gbl_mux),
        .loc_mode(loc_mode), .loc_pol(loc_pol), .oe_pin_n(oe_pin_n), .clk_pin_lvl(clk_pin_lvl),
        .io_pin(io_pin), .adj_pin(adj_pin), .pre_en(pre_en), .pre_val(pre_val),
        .pad_data(act_pd[1]), .pad_oe(act_oe[1]), .fb_out(act_fb[1]));

    pld_macrocell #(.CELL_ID(7)) uut_end7 (
        .clk(clk), .rst_n(rst_n), .terms(terms), .gbl_noreg(gbl_noreg), .gbl_mux(gbl_mux),
        .loc_mode(loc_mode), .loc_pol(loc_pol), .oe_pin_n(oe_pin_n), .clk_pin_lvl(clk_pin_lvl),
        .io_pin(io_pin), .adj_pin(adj_pin), .pre_en(pre_en), .pre_val(pre_val),
        .pad_data(act_pd[2]), .pad_oe(act_oe[2]), .fb_out(act_fb[2]));

    pld_macrocell #(.CELL_ID(3)) uut_mid (
        .clk(clk), .rst_n(rst_n), .terms(terms), .gbl_noreg(gbl_noreg), .gbl_mux(gbl_mux),
        .loc_mode(loc_mode), .loc_pol(loc_pol), .oe_pin_n(oe_pin_n), .clk_pin_lvl(clk_pin_lvl),
        .io_pin(io_pin), .adj_pin(adj_pin), .pre_en(pre_en), .pre_val(pre_val),
        .pad_data(act_pd[3]), .pad_oe(act_oe[3]), .fb_out(act_fb[3]));

    task automatic expect_out(input int unit, input string tag,
                              input logic pd, input logic oe, input logic fb);
        exp_t e;
        e.unit = unit; e.tag = tag; e.pd = pd; e.oe = oe; e.fb = fb;
        exp_q.push_back(e);
    endtask

    task automatic set_mode(input logic g0, input logic g1, input logic l0);
        gbl_noreg = g0; gbl_mux = g1; loc_mode = l0;
    endtask

    // Monitor: one cycle after the driver, past the capturing edge
    always @(posedge clk) begin
        #1;
        while (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (act_pd[e.unit] !== e.pd || act_oe[e.unit] !== e.oe || act_fb[e.unit] !== e.fb) begin
                errors++;
                $display("FAIL %s unit %0d: actual pd=%b oe=%b fb=%b expected pd=%b oe=%b fb=%b",
                         e.tag, e.unit, act_pd[e.unit], act_oe[e.unit], act_fb[e.unit],
                         e.pd, e.oe, e.fb);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8 reset: registered mode, flop cleared, pad reads high
        @(negedge clk);
        set_mode(1'b0, 1'b1, 1'b0); terms = 8'hFF; loc_pol = 1'b1; oe_pin_n = 1'b0;
        expect_out(0, "R8 reset pad high", 1'b1, 1'b1, 1'b1);
        expect_out(1, "R8 reset end cell", 1'b1, 1'b1, 1'b1);

        // R1 capture of zero sum
        @(negedge clk);
        rst_n = 1'b1; terms = 8'h00;
        expect_out(0, "R1 capture zero", 1'b0, 1'b1, 1'b0);

        // R1/R7 capture of one; end cell feeds back register, not OE level (0)
        @(negedge clk);
        terms = 8'h01;
        expect_out(0, "R1 capture one", 1'b1, 1'b1, 1'b1);
        expect_out(1, "R7 end cell registered feedback", 1'b1, 1'b1, 1'b1);

        // R2 active-low registered
        @(negedge clk);
        loc_pol = 1'b0;
        expect_out(0, "R2 active low registered", 1'b0, 1'b1, 1'b0);

        // R1 enable follows OE pin
        @(negedge clk);
        terms = 8'h00; oe_pin_n = 1'b1;
        expect_out(0, "R1 OE pin disables pad", 1'b1, 1'b0, 1'b1);

        // R9 preload overrides capture of an opposite value
        @(negedge clk);
        pre_en = 1'b1; pre_val = 1'b0; terms = 8'hFF; loc_pol = 1'b1;
        expect_out(0, "R9 preload zero", 1'b0, 1'b0, 1'b0);

        @(negedge clk);
        pre_val = 1'b1; terms = 8'h00;
        expect_out(0, "R9 preload one", 1'b1, 1'b0, 1'b1);

        // R3 combinatorial I/O in registered device
        @(negedge clk);
        pre_en = 1'b0; oe_pin_n = 1'b0; set_mode(1'b0, 1'b1, 1'b1);
        terms = 8'h80; io_pin = 1'b1;
        expect_out(0, "R3 enable term only", 1'b0, 1'b1, 1'b1);

        @(negedge clk);
        terms = 8'h04; io_pin = 1'b0;
        expect_out(0, "R3 data term no enable", 1'b1, 1'b0, 1'b0);

        // R4 dedicated combinatorial output
        @(negedge clk);
        set_mode(1'b1, 1'b0, 1'b0); terms = 8'h80; loc_pol = 1'b1; adj_pin = 1'b1;
        expect_out(0, "R4 eight terms used", 1'b1, 1'b1, 1'b1);
        expect_out(3, "R4 middle cell no feedback", 1'b1, 1'b1, 1'b0);

        @(negedge clk);
        loc_pol = 1'b0;
        expect_out(0, "R2 active low combinatorial", 1'b0, 1'b1, 1'b1);
        expect_out(3, "R4 middle cell active low", 1'b0, 1'b1, 1'b0);

        // R5/R7 dedicated input
        @(negedge clk);
        set_mode(1'b1, 1'b0, 1'b1); oe_pin_n = 1'b0; clk_pin_lvl = 1'b1; io_pin = 1'b0;
        expect_out(0, "R5 input adjacent feedback", 1'b0, 1'b0, 1'b1);
        expect_out(1, "R7 first end cell takes OE level", 1'b0, 1'b0, 1'b0);
        expect_out(2, "R7 last end cell takes clock level", 1'b0, 1'b0, 1'b1);

        // R6/R7 combinatorial I/O in non-registered device
        @(negedge clk);
        set_mode(1'b1, 1'b1, 1'b1); terms = 8'h81; loc_pol = 1'b1;
        io_pin = 1'b0; oe_pin_n = 1'b1; clk_pin_lvl = 1'b0; adj_pin = 1'b1;
        expect_out(0, "R6 seven terms with enable", 1'b1, 1'b1, 1'b0);
        expect_out(1, "R7 first end cell in mode 111", 1'b1, 1'b1, 1'b1);
        expect_out(2, "R7 last end cell in mode 111", 1'b1, 1'b1, 1'b0);

        @(negedge clk);
        terms = 8'h80; io_pin = 1'b1;
        expect_out(0, "R6 eighth term excluded from sum", 1'b0, 1'b1, 1'b1);

        // R10 unlisted codes
        @(negedge clk);
        set_mode(1'b0, 1'b0, 1'b0); terms = 8'hFF; io_pin = 1'b1;
        expect_out(0, "R10 code 000", 1'b0, 1'b0, 1'b1);

        @(negedge clk);
        set_mode(1'b1, 1'b1, 1'b0); io_pin = 1'b0;
        expect_out(0, "R10 code 110", 1'b0, 1'b0, 1'b0);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule